// File: doc/BRIEF.md
# TFT Panel Strobe Timing Generator

This block derives the five line- and frame-rate control strobes of a portrait TFT panel (240 pixels wide, 320 visible lines plus 9 blanking lines, refreshed at 60 frames per second) from a single dot clock. Each strobe comes from its own period and width counter, and all periods are tied to one line period. With the default 6 MHz dot clock, truncating (6 000 000 / 60) / 329 gives a line period of 303 dot clocks. The five strobes are:

- a line pulse,
- a start pulse,
- a once-per-frame vertical start,
- a combined polarity/clock-select strobe,
- a polarity-reversal strobe.

The strobes do not start together. When `enable` rises, the block starts the reversal strobe first. It starts the line pulse once the reversal counter has passed 11. It starts the remaining three once the line-pulse counter has reached 3, and then asserts `done`. When `enable` drops, every counter stops at once, every strobe goes low and `done` clears. The next `enable` therefore runs the whole staggered start again. The line period, the frame length in lines, the active pixel width and the lead-in count are parameters.

Top module: `tft_strobe_gen`

## Requirements
- R1: During and after synchronous reset, with `enable` low, all five strobe outputs and `done` are 0.
- R2: Once started, `lpOut` is high for exactly 1 clock in every LINE_CLKS clocks.
- R3: Once started, `spOut` is high for exactly 1 clock in every LINE_CLKS clocks, and it rises 4 clocks after a `lpOut` rise.
- R4: `spsOut` is high for 2*LINE_CLKS clocks. Its rising edges are exactly LINE_CLKS*FRAME_LINES clocks apart.
- R5: `psClsOut` has the inverted sense. In each line it is low for ACTIVE_PIX+LEAD_LINES clocks and then high for the rest of the LINE_CLKS period.
- R6: `revOut` is high for LINE_CLKS clocks and then low for LINE_CLKS clocks, alternating every line.
- R7: Start order. Number the rising clock edges from 1, with edge 1 being the first edge that samples `enable` high. `revOut` goes high after edge 1. `lpOut` goes high after edge 14, when the reversal count has exceeded 11. `spOut`, `spsOut` and `done` go high after edge 18, when the line-pulse count has reached 3.
- R8: The first edge that samples `enable` low forces all five strobes and `done` to 0. A later `enable` repeats the full R7 sequence with the same edge counts.
- R9: If `enable` drops before `done` has asserted, `done` stays 0. The next `enable` restarts from the reversal strobe, with the R7 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run request; high starts the staggered sequence, low stops everything |
| lpOut | output | 1 | Line pulse strobe |
| spOut | output | 1 | Start pulse strobe |
| spsOut | output | 1 | Frame (vertical) start strobe |
| psClsOut | output | 1 | Polarity/clock-select strobe, inverted sense |
| revOut | output | 1 | Line polarity reversal strobe |
| done | output | 1 | All five strobes running |

## Verification
A counter that wraps one clock early or late shows up within a single line period as a wrong pulse width or a wrong rise-to-rise spacing. For the frame strobe the same fault only appears after a full frame, as a wrong spacing between two frame starts. A wrong sequencer state or a wrong gate threshold moves the rise of `lpOut` or `done` by whole clocks relative to the edge that saw `enable`, so the edge counts in R7 expose it during start-up. An enable that does not clear properly shows within one clock of `enable` falling as a strobe or `done` left high, or later as a shortened restart.

// File: rtl/tft_strobe_pkg.sv
package tft_strobe_pkg;
  localparam int NUM_STROBES = 5;
  localparam int IDX_LP  = 0;
  localparam int IDX_SP  = 1;
  localparam int IDX_SPS = 2;
  localparam int IDX_PS  = 3;
  localparam int IDX_REV = 4;

  // control -> datapath: which counter groups may run
  typedef struct packed {
    logic rev;
    logic lp;
    logic group;   // SP, SPS and PS/CLS start together
  } runCtl_t;

  // datapath -> control: gate thresholds reached
  typedef struct packed {
    logic revPast;
    logic lpPast;
  } gateStat_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_REV,
    ST_WAIT_LP,
    ST_RUN
  } seqState_t;
endpackage

// File: rtl/strobe_timer.sv
module strobe_timer #(
  parameter int CW     = 17,
  parameter int PERIOD = 303,
  parameter int WIDTH  = 1,
  parameter bit INVERT = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  output logic [CW-1:0] count,
  output logic          pulse
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  localparam logic [CW-1:0] WLIM = CW'(WIDTH);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  logic inWidth;
  assign inWidth = (cnt < WLIM);
  assign pulse   = run & (inWidth ^ INVERT);
  assign count   = cnt;
endmodule

// File: rtl/strobe_datapath.sv
module strobe_datapath
  import tft_strobe_pkg::*;
#(
  parameter int LINE_CLKS   = 303,
  parameter int FRAME_LINES = 329,
  parameter int PS_WIDTH    = 248,
  parameter int REV_GATE    = 11,
  parameter int LP_GATE     = 3,
  localparam int CW = $clog2(LINE_CLKS * FRAME_LINES + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  runCtl_t                ctl,
  output gateStat_t              stat,
  output logic [NUM_STROBES-1:0] strobes
);
  logic [CW-1:0] counts [NUM_STROBES];
  logic [NUM_STROBES-1:0] runs;

  assign runs[IDX_LP]  = ctl.lp;
  assign runs[IDX_SP]  = ctl.group;
  assign runs[IDX_SPS] = ctl.group;
  assign runs[IDX_PS]  = ctl.group;
  assign runs[IDX_REV] = ctl.rev;

  for (genvar i = 0; i < NUM_STROBES; i++) begin : g_timer
    localparam int PER =
      (i == IDX_SPS) ? LINE_CLKS * FRAME_LINES :
      (i == IDX_REV) ? 2 * LINE_CLKS : LINE_CLKS;
    localparam int WID =
      (i == IDX_SPS) ? 2 * LINE_CLKS :
      (i == IDX_REV) ? LINE_CLKS :
      (i == IDX_PS)  ? PS_WIDTH : 1;
    localparam bit INV = (i == IDX_PS);

    strobe_timer #(.CW(CW), .PERIOD(PER), .WIDTH(WID), .INVERT(INV)) u_tmr (
      .clk  (clk),
      .rst  (rst),
      .run  (runs[i]),
      .count(counts[i]),
      .pulse(strobes[i])
    );
  end

  assign stat.revPast = (counts[IDX_REV] > CW'(REV_GATE));
  assign stat.lpPast  = (counts[IDX_LP] >= CW'(LP_GATE));
endmodule

// File: rtl/strobe_seq_ctrl.sv
module strobe_seq_ctrl
  import tft_strobe_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      enable,
  input  gateStat_t stat,
  output runCtl_t   ctl,
  output logic      done
);
  seqState_t state;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      state <= ST_IDLE;
      ctl   <= '0;
      done  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          ctl.rev <= 1'b1;
          state   <= ST_WAIT_REV;
        end
        ST_WAIT_REV: if (stat.revPast) begin
          ctl.lp <= 1'b1;
          state  <= ST_WAIT_LP;
        end
        ST_WAIT_LP: if (stat.lpPast) begin
          ctl.group <= 1'b1;
          done      <= 1'b1;
          state     <= ST_RUN;
        end
        default: state <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/tft_strobe_gen.sv
module tft_strobe_gen
  import tft_strobe_pkg::*;
#(
  parameter int LINE_CLKS   = 303,
  parameter int FRAME_LINES = 329,
  parameter int ACTIVE_PIX  = 240,
  parameter int LEAD_LINES  = 8,
  parameter int REV_GATE    = 11,
  parameter int LP_GATE     = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  output logic lpOut,
  output logic spOut,
  output logic spsOut,
  output logic psClsOut,
  output logic revOut,
  output logic done
);
  localparam int PS_WIDTH = ACTIVE_PIX + LEAD_LINES;

  runCtl_t                ctlBus;
  gateStat_t              statBus;
  logic [NUM_STROBES-1:0] strobeVec;

  strobe_seq_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .enable(enable),
    .stat  (statBus),
    .ctl   (ctlBus),
    .done  (done)
  );

  strobe_datapath #(
    .LINE_CLKS  (LINE_CLKS),
    .FRAME_LINES(FRAME_LINES),
    .PS_WIDTH   (PS_WIDTH),
    .REV_GATE   (REV_GATE),
    .LP_GATE    (LP_GATE)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctlBus),
    .stat   (statBus),
    .strobes(strobeVec)
  );

  assign lpOut    = strobeVec[IDX_LP];
  assign spOut    = strobeVec[IDX_SP];
  assign spsOut   = strobeVec[IDX_SPS];
  assign psClsOut = strobeVec[IDX_PS];
  assign revOut   = strobeVec[IDX_REV];
endmodule

// File: rtl/tft_strobe_gen_chk.sv
module tft_strobe_gen_chk
  import tft_strobe_pkg::*;
(
  input logic                   clk,
  input logic                   rst,
  input logic                   enable,
  input logic                   done,
  input logic [NUM_STROBES-1:0] strobes,
  input runCtl_t                ctl
);
  a_r2_lp_single: assert property (@(posedge clk) disable iff (rst)
    strobes[IDX_LP] |=> !strobes[IDX_LP]);

  a_r3_sp_single: assert property (@(posedge clk) disable iff (rst)
    strobes[IDX_SP] |=> !strobes[IDX_SP]);

  a_r6_rev_holds: assert property (@(posedge clk) disable iff (rst)
    (enable && $rose(strobes[IDX_REV])) |=> (strobes[IDX_REV] || !enable));

  a_r7_order: assert property (@(posedge clk) disable iff (rst)
    ctl.group |-> (ctl.lp && ctl.rev));

  a_r7_lp_after_rev: assert property (@(posedge clk) disable iff (rst)
    ctl.lp |-> ctl.rev);

  a_r7_done_running: assert property (@(posedge clk) disable iff (rst)
    done |-> ctl.group);

  a_r8_stop_all: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (strobes == '0 && !done));
endmodule

bind tft_strobe_gen tft_strobe_gen_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .enable (enable),
  .done   (done),
  .strobes(strobeVec),
  .ctl    (ctlBus)
);

// File: tb/tb_tft_strobe_gen.sv
module tb_tft_strobe_gen;
  localparam int LINE   = 40;
  localparam int FRAME  = 10;
  localparam int APIX   = 24;
  localparam int LEAD   = 4;
  localparam int PSW    = APIX + LEAD;
  localparam int I_LP = 0, I_SP = 1, I_SPS = 2, I_PS = 3, I_REV = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic lpOut, spOut, spsOut, psClsOut, revOut, done;

  int cyc = 0;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tft_strobe_gen #(
    .LINE_CLKS(LINE), .FRAME_LINES(FRAME), .ACTIVE_PIX(APIX), .LEAD_LINES(LEAD)
  ) dut (
    .clk(clk), .rst(rst), .enable(enable),
    .lpOut(lpOut), .spOut(spOut), .spsOut(spsOut),
    .psClsOut(psClsOut), .revOut(revOut), .done(done)
  );

  logic [4:0] obs;
  assign obs = {revOut, psClsOut, spsOut, spOut, lpOut};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // wait (sampling at negedge) until strobe idx equals lvl
  task automatic waitLevel(input int idx, input bit lvl, input string req);
    int guard = 0;
    @(negedge clk);
    while (obs[idx] != lvl && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 2000) check(1'b0, req, 0, 1);
  endtask

  // high time and rise-to-rise spacing of one strobe
  task automatic measure(input int idx, input string req, output int hi, output int per);
    int t0;
    waitLevel(idx, 1'b0, req);
    waitLevel(idx, 1'b1, req);
    t0 = cyc;
    waitLevel(idx, 1'b0, req);
    hi = cyc - t0;
    waitLevel(idx, 1'b1, req);
    per = cyc - t0;
  endtask

  // enable at a negedge, return cycles until done seen
  task automatic startAndTime(output int revAt, output int lpAt, output int doneAt);
    int c0;
    revAt = -1; lpAt = -1; doneAt = -1;
    @(negedge clk);
    enable = 1'b1;
    c0 = cyc;
    for (int k = 0; k < 60 && doneAt < 0; k++) begin
      @(negedge clk);
      if (revOut && revAt < 0) revAt = cyc - c0;
      if (lpOut && lpAt < 0) lpAt = cyc - c0;
      if (done && doneAt < 0) begin
        doneAt = cyc - c0;
        check(spOut && spsOut, "R7 sp/sps rise with done", int'({spOut, spsOut}), 3);
      end
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(obs == 5'b0 && !done, "R1 reset state", int'({obs, done}), 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check(obs == 5'b0 && !done, "R1 idle with enable low", int'({obs, done}), 0);
  endtask

  task automatic t_startup();
    int r, l, d;
    startAndTime(r, l, d);
    check(r == 1, "R7 rev starts first", r, 1);
    check(l == 14, "R7 lp start edge", l, 14);
    check(d == 18, "R7 done edge", d, 18);
  endtask

  task automatic t_lp();
    int hi, per;
    measure(I_LP, "R2 lp", hi, per);
    check(hi == 1, "R2 lp width", hi, 1);
    check(per == LINE, "R2 lp period", per, LINE);
  endtask

  task automatic t_sp();
    int hi, per, t0;
    measure(I_SP, "R3 sp", hi, per);
    check(hi == 1, "R3 sp width", hi, 1);
    check(per == LINE, "R3 sp period", per, LINE);
    waitLevel(I_LP, 1'b1, "R3 lp");
    t0 = cyc;
    waitLevel(I_SP, 1'b1, "R3 sp");
    check(cyc - t0 == 4, "R3 sp after lp", cyc - t0, 4);
  endtask

  task automatic t_sps();
    int hi, per;
    measure(I_SPS, "R4 sps", hi, per);
    check(hi == 2 * LINE, "R4 sps width", hi, 2 * LINE);
    check(per == LINE * FRAME, "R4 sps frame spacing", per, LINE * FRAME);
  endtask

  task automatic t_ps();
    int hi, per, t0, lo;
    measure(I_PS, "R5 ps", hi, per);
    check(per == LINE, "R5 ps period", per, LINE);
    check(hi == LINE - PSW, "R5 ps high part", hi, LINE - PSW);
    waitLevel(I_PS, 1'b0, "R5 ps");
    t0 = cyc;
    waitLevel(I_PS, 1'b1, "R5 ps");
    lo = cyc - t0;
    check(lo == PSW, "R5 ps low part", lo, PSW);
  endtask

  task automatic t_rev();
    int hi, per;
    measure(I_REV, "R6 rev", hi, per);
    check(hi == LINE, "R6 rev high", hi, LINE);
    check(per == 2 * LINE, "R6 rev period", per, 2 * LINE);
  endtask

  task automatic t_disable();
    int r, l, d;
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(obs == 5'b0 && !done, "R8 stop after disable", int'({obs, done}), 0);
    repeat (10) @(negedge clk);
    check(obs == 5'b0 && !done, "R8 stays stopped", int'({obs, done}), 0);
    startAndTime(r, l, d);
    check(l == 14 && d == 18, "R8 restart repeats sequence", l * 100 + d, 1418);
  endtask

  task automatic t_abort();
    int r, l, d;
    bit sawDone = 1'b0;
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    repeat (8) begin
      @(negedge clk);
      if (done) sawDone = 1'b1;
    end
    enable = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (done) sawDone = 1'b1;
    end
    check(!sawDone, "R9 no done after early drop", int'(sawDone), 0);
    startAndTime(r, l, d);
    check(r == 1 && l == 14 && d == 18, "R9 restart from rev", r * 10000 + l * 100 + d, 11418);
  endtask

  initial begin
    t_reset();
    t_startup();
    t_lp();
    t_sp();
    t_sps();
    t_ps();
    t_rev();
    t_disable();
    t_sps();
    t_abort();
    t_lp();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule